// File: doc/BRIEF.md
# Interrupt Status and Soft Reset Register Block

This block holds three processor-visible registers for a packet interface bridge, reached over a simple bus with address, write strobe, write data and combinational read data. It has a sticky interrupt status register, an enable mask that lines up with it bit for bit, and a soft reset register. The status register collects events from the datapath monitors. Error monitors give single-cycle pulses. Synchronisation and clock-presence monitors give level signals, and the block turns those into edge events itself.

The masked status bits are OR-reduced into one summary line. That line feeds one field of the chip's primary interrupt register. Software clears status bits by writing ones to them. Writing a one to the soft reset bit has the same effect on these registers as a hardware reset. It also emits a one-cycle internal reset pulse and starts a fixed initialisation sequence. While that sequence runs, the reset bit reads 1. When the sequence ends, the reset bit returns to 0 and the init-done flag is set.

Top module: `isr_softrst_regs`

## Requirements
- R1: After hardware reset, the status register (default offset 2) and the mask register (default offset 3) read 0x00, and the soft reset register (default offset 0) reads 0x00.
- R2: Status bits are sticky. A write to the status register clears every bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R3: Status bit 1 follows the ingress sync level and status bit 6 follows the egress sync level. Each bit is set on a change of its level in either direction.
- R4: A pulse sets the matching status bit on the next clock edge: ingress parity error sets bit 0, ingress bus error sets bit 2, ingress idle transfer sets bit 3, and egress parity error sets bit 5.
- R5: Status bit 4 is set when the ingress clock-ok level falls from 1 to 0, and status bit 7 is set when the egress clock-ok level falls from 1 to 0. Neither bit is set while its level stays at 0 or when the level rises.
- R6: If an event and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R7: The mask register reads back what was written. The summary interrupt is 1 exactly when some status bit and its mask bit are both 1.
- R8: While low-speed mode is 1, status bit 7 reads 0 and is never set. A bit 7 that was already set is cleared.
- R9: Writing 1 to bit 0 of the soft reset register makes bit 0 read 1 and bit 1 (init-done) read 0, and raises the reset pulse output for one cycle. Bit 0 then reads 0 and bit 1 reads 1 starting 16 clock edges after the write edge. Writing 0 to bit 0 has no effect.
- R10: A soft reset clears the status and mask registers on the write edge.
- R11: Bits 7:2 of the soft reset register read 0 and ignore writes. Unmapped offsets read 0, and writes to them change nothing.
- R12: After hardware reset is released, init-done reads 0 for 15 clock edges and reads 1 from the 16th edge on.
- R13: Levels that hold steady from reset release raise no status bit. The first edge after release only captures the level history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | ADDR_W (6) | Register offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for bus_addr (combinational) |
| ing_parity_err | input | 1 | Ingress parity error pulse |
| ing_bus_err | input | 1 | Ingress bus error pulse |
| ing_idle_xfer | input | 1 | Ingress transfer on an inactive channel pulse |
| egr_parity_err | input | 1 | Egress status parity error pulse |
| ing_sync_ok | input | 1 | Ingress in-sync level |
| egr_sync_ok | input | 1 | Egress status in-sync level |
| ing_clk_ok | input | 1 | Ingress data clock present level |
| egr_clk_ok | input | 1 | Egress status clock present level |
| low_speed_mode | input | 1 | Single-ended interface mode; the egress clock is not monitored |
| irq_summary | output | 1 | OR of the masked status bits |
| core_rst_pulse | output | 1 | One-cycle pulse after a soft reset request |

## Verification
Three pairs of functions can fall in the same cycle. An event can arrive while software writes a one to clear the same bit. Low-speed mode can be active while an egress clock loss occurs. A soft reset can be requested while events arrive. Directed cases line up each pair on one edge. The random phase drives pulses, level toggles, clear writes, mask writes and rare soft resets with independent probabilities, so such coincidences also occur often without being targeted. Every cycle, the bench predicts the register contents, the summary line and the reset pulse from the requirements and compares them at the ports.

// File: rtl/isr_regs_pkg.sv
package isr_regs_pkg;
   localparam int unsigned STAT_W = 8;

   // Status bit positions (software decodes these)
   localparam int unsigned B_ING_PAR  = 0;
   localparam int unsigned B_ING_SYNC = 1;
   localparam int unsigned B_ING_BUS  = 2;
   localparam int unsigned B_ING_IDLE = 3;
   localparam int unsigned B_ING_CLK  = 4;
   localparam int unsigned B_EGR_PAR  = 5;
   localparam int unsigned B_EGR_SYNC = 6;
   localparam int unsigned B_EGR_CLK  = 7;

   // Level-monitor channel indices
   localparam int unsigned CH_ING = 0;
   localparam int unsigned CH_EGR = 1;
   localparam int unsigned N_CH   = 2;

   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_MASK,
      SEL_RST
   } reg_sel_e;
endpackage

// File: rtl/isr_level_mon.sv
module isr_level_mon #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sync_lvl,
   input  logic [N-1:0] clk_ok_lvl,
   output logic [N-1:0] sync_chg,
   output logic [N-1:0] clk_lost
);
   logic         hist_vld;
   logic [N-1:0] sync_q;
   logic [N-1:0] clk_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_vld <= 1'b0;
      end else begin
         hist_vld <= 1'b1;
      end
   end

   for (genvar c = 0; c < N; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q[c]   <= 1'b0;
            clk_ok_q[c] <= 1'b0;
         end else begin
            sync_q[c]   <= sync_lvl[c];
            clk_ok_q[c] <= clk_ok_lvl[c];
         end
      end
      // Edges count only once a real history sample exists
      assign sync_chg[c] = hist_vld & (sync_lvl[c] ^ sync_q[c]);
      assign clk_lost[c] = hist_vld & clk_ok_q[c] & ~clk_ok_lvl[c];
   end
endmodule

// File: rtl/isr_status_bank.sv
module isr_status_bank #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] w1c_vec,
   input  logic [W-1:0] force_zero,
   input  logic         mask_we,
   input  logic [W-1:0] mask_wdata,
   output logic [W-1:0] stat_q,
   output logic [W-1:0] mask_q,
   output logic         irq
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stat_q[b] <= 1'b0;
         end else if (clr_all || force_zero[b]) begin
            stat_q[b] <= 1'b0;
         end else if (set_vec[b]) begin
            stat_q[b] <= 1'b1;   // event beats a same-cycle clear
         end else if (w1c_vec[b]) begin
            stat_q[b] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (clr_all) begin
         mask_q <= '0;
      end else if (mask_we) begin
         mask_q <= mask_wdata;
      end
   end

   assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/isr_soft_rst.sv
module isr_soft_rst #(
   parameter int unsigned INIT_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic rst_bit,
   output logic init_done,
   output logic rst_pulse
);
   localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(INIT_CYCLES);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= CNT_LOAD;
         init_done <= 1'b0;
         rst_bit   <= 1'b0;
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= req;
         if (req) begin
            cnt_q     <= CNT_LOAD;
            init_done <= 1'b0;
            rst_bit   <= 1'b1;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_LAST;
            if (cnt_q == CNT_LAST) begin
               init_done <= 1'b1;
               rst_bit   <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/isr_softrst_regs.sv
module isr_softrst_regs
   import isr_regs_pkg::*;
#(
   parameter int unsigned ADDR_W      = 6,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_RST    = 0,
   parameter int unsigned ADDR_STAT   = 2,
   parameter int unsigned ADDR_MASK   = 3,
   parameter int unsigned INIT_CYCLES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ing_parity_err,
   input  logic              ing_bus_err,
   input  logic              ing_idle_xfer,
   input  logic              egr_parity_err,
   input  logic              ing_sync_ok,
   input  logic              egr_sync_ok,
   input  logic              ing_clk_ok,
   input  logic              egr_clk_ok,
   input  logic              low_speed_mode,
   output logic              irq_summary,
   output logic              core_rst_pulse
);
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   // Elaboration-time parameter checks
   if (DATA_W < STAT_W) begin : g_bad_width
      $error("DATA_W must cover the status width");
   end
   if (ADDR_RST >= ADDR_SPAN || ADDR_STAT >= ADDR_SPAN || ADDR_MASK >= ADDR_SPAN) begin : g_bad_addr
      $error("register offset outside address space");
   end
   if (ADDR_RST == ADDR_STAT || ADDR_RST == ADDR_MASK || ADDR_STAT == ADDR_MASK) begin : g_dup_addr
      $error("register offsets must differ");
   end
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("INIT_CYCLES must be at least 1");
   end

   reg_sel_e          sel;
   logic [STAT_W-1:0] stat_q, mask_q, set_vec, w1c_vec, force_zero;
   logic [N_CH-1:0]   sync_chg, clk_lost;
   logic              soft_req, rst_bit, init_done;

   always_comb begin
      if (bus_addr == ADDR_W'(ADDR_STAT))      sel = SEL_STAT;
      else if (bus_addr == ADDR_W'(ADDR_MASK)) sel = SEL_MASK;
      else if (bus_addr == ADDR_W'(ADDR_RST))  sel = SEL_RST;
      else                                     sel = SEL_NONE;
   end

   assign soft_req = bus_we && (sel == SEL_RST) && bus_wdata[0];
   assign w1c_vec  = (bus_we && sel == SEL_STAT) ? bus_wdata[STAT_W-1:0] : '0;

   isr_level_mon #(.N(N_CH)) u_mon (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_lvl   ({egr_sync_ok, ing_sync_ok}),
      .clk_ok_lvl ({egr_clk_ok, ing_clk_ok}),
      .sync_chg   (sync_chg),
      .clk_lost   (clk_lost)
   );

   always_comb begin
      set_vec             = '0;
      set_vec[B_ING_PAR]  = ing_parity_err;
      set_vec[B_ING_SYNC] = sync_chg[CH_ING];
      set_vec[B_ING_BUS]  = ing_bus_err;
      set_vec[B_ING_IDLE] = ing_idle_xfer;
      set_vec[B_ING_CLK]  = clk_lost[CH_ING];
      set_vec[B_EGR_PAR]  = egr_parity_err;
      set_vec[B_EGR_SYNC] = sync_chg[CH_EGR];
      set_vec[B_EGR_CLK]  = clk_lost[CH_EGR];
      force_zero             = '0;
      force_zero[B_EGR_CLK]  = low_speed_mode;
   end

   isr_status_bank #(.W(STAT_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_all    (soft_req),
      .set_vec    (set_vec),
      .w1c_vec    (w1c_vec),
      .force_zero (force_zero),
      .mask_we    (bus_we && sel == SEL_MASK),
      .mask_wdata (bus_wdata[STAT_W-1:0]),
      .stat_q     (stat_q),
      .mask_q     (mask_q),
      .irq        (irq_summary)
   );

   isr_soft_rst #(.INIT_CYCLES(INIT_CYCLES)) u_rst (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (soft_req),
      .rst_bit   (rst_bit),
      .init_done (init_done),
      .rst_pulse (core_rst_pulse)
   );

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_STAT: bus_rdata[STAT_W-1:0] = stat_q;
         SEL_MASK: bus_rdata[STAT_W-1:0] = mask_q;
         SEL_RST: begin
            bus_rdata[1] = init_done;
            bus_rdata[0] = rst_bit;
         end
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/isr_regs_chk.sv
module isr_regs_chk #(
   parameter int unsigned ADDR_W    = 6,
   parameter int unsigned ADDR_RST  = 0,
   parameter int unsigned ADDR_STAT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              wdata0,
   input logic              ing_sync_ok,
   input logic              ing_clk_ok,
   input logic              low_speed_mode,
   input logic              core_rst_pulse,
   input logic [7:0]        stat_q,
   input logic [7:0]        mask_q,
   input logic              rst_bit,
   input logic              init_done
);
   logic stat_wr, rst_wr;
   assign stat_wr = bus_we && (bus_addr == ADDR_W'(ADDR_STAT));
   assign rst_wr  = bus_we && (bus_addr == ADDR_W'(ADDR_RST)) && wdata0;

   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_wr && !rst_wr) |=> ((stat_q[6:0] & $past(stat_q[6:0])) == $past(stat_q[6:0])));

   p_sync_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[1]) |-> ($past(ing_sync_ok, 2) != $past(ing_sync_ok)));

   p_clk_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[4]) |-> ($past(ing_clk_ok, 2) && !$past(ing_clk_ok)));

   p_low_speed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(low_speed_mode) |-> !stat_q[7]);

   p_pulse_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_pulse) |-> $past(rst_wr));

   p_done_on_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_bit) |-> init_done);

   p_soft_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst_pulse |-> (stat_q == 8'h00 && mask_q == 8'h00));
endmodule

bind isr_softrst_regs isr_regs_chk #(
   .ADDR_W    (ADDR_W),
   .ADDR_RST  (ADDR_RST),
   .ADDR_STAT (ADDR_STAT)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .bus_addr       (bus_addr),
   .bus_we         (bus_we),
   .wdata0         (bus_wdata[0]),
   .ing_sync_ok    (ing_sync_ok),
   .ing_clk_ok     (ing_clk_ok),
   .low_speed_mode (low_speed_mode),
   .core_rst_pulse (core_rst_pulse),
   .stat_q         (stat_q),
   .mask_q         (mask_q),
   .rst_bit        (rst_bit),
   .init_done      (init_done)
);

// File: tb/tb_isr_softrst_regs.sv
module tb_isr_softrst_regs;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int DW = 8;
   localparam logic [AW-1:0] A_RST  = 6'd0;
   localparam logic [AW-1:0] A_STAT = 6'd2;
   localparam logic [AW-1:0] A_MASK = 6'd3;
   localparam int INIT = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic bus_we = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic ing_parity_err = 0, ing_bus_err = 0, ing_idle_xfer = 0, egr_parity_err = 0;
   logic ing_sync_ok = 1, egr_sync_ok = 0, ing_clk_ok = 1, egr_clk_ok = 1;
   logic low_speed_mode = 0;
   logic irq_summary, core_rst_pulse;

   always #(CLK_PERIOD/2) clk = ~clk;

   isr_softrst_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ing_parity_err(ing_parity_err), .ing_bus_err(ing_bus_err),
      .ing_idle_xfer(ing_idle_xfer), .egr_parity_err(egr_parity_err),
      .ing_sync_ok(ing_sync_ok), .egr_sync_ok(egr_sync_ok),
      .ing_clk_ok(ing_clk_ok), .egr_clk_ok(egr_clk_ok),
      .low_speed_mode(low_speed_mode), .irq_summary(irq_summary),
      .core_rst_pulse(core_rst_pulse)
   );

   int n_chk = 0;
   int n_fail = 0;

   // Requirement-level model
   logic [7:0] m_stat = 0, m_mask = 0;
   int   m_cnt = INIT;
   logic m_done = 0, m_bit = 0, m_pulse = 0, m_hv = 0;
   logic m_isync = 0, m_esync = 0, m_iclk = 0, m_eclk = 0;

   function automatic logic [7:0] exp_rd(logic [AW-1:0] a);
      if (a == A_STAT) return m_stat;
      if (a == A_MASK) return m_mask;
      if (a == A_RST)  return {6'b0, m_done, m_bit};
      return 8'h00;
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic step();
      logic [7:0] set, clr;
      logic sreq;
      sreq = bus_we && bus_addr == A_RST && bus_wdata[0];
      set = 8'h00;
      set[0] = ing_parity_err; set[2] = ing_bus_err;
      set[3] = ing_idle_xfer;  set[5] = egr_parity_err;
      if (m_hv) begin
         set[1] = ing_sync_ok != m_isync;
         set[6] = egr_sync_ok != m_esync;
         set[4] = m_iclk && !ing_clk_ok;
         set[7] = m_eclk && !egr_clk_ok;
      end
      clr = (bus_we && bus_addr == A_STAT) ? bus_wdata : 8'h00;
      if (sreq) begin
         m_stat = 0; m_mask = 0;
      end else begin
         m_stat = (m_stat & ~clr) | set;
         if (low_speed_mode) m_stat[7] = 1'b0;
         if (bus_we && bus_addr == A_MASK) m_mask = bus_wdata;
      end
      m_pulse = sreq;
      if (sreq) begin
         m_cnt = INIT; m_done = 0; m_bit = 1;
      end else if (m_cnt > 0) begin
         m_cnt--;
         if (m_cnt == 0) begin m_done = 1; m_bit = 0; end
      end
      m_isync = ing_sync_ok; m_esync = egr_sync_ok;
      m_iclk = ing_clk_ok;   m_eclk = egr_clk_ok;
      m_hv = 1;
      @(posedge clk);
      @(negedge clk);
      ing_parity_err = 0; ing_bus_err = 0; ing_idle_xfer = 0; egr_parity_err = 0;
      bus_we = 0; bus_wdata = 0;
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      bus_addr = a; bus_we = 1; bus_wdata = d;
      step();
   endtask

   task automatic rd(logic [AW-1:0] a, string tag, logic [7:0] exp);
      bus_addr = a; #1;
      check(tag, bus_rdata, exp);
      check({tag, " (model)"}, bus_rdata, exp_rd(a));
   endtask

   task automatic chk_irq(string tag);
      check(tag, {7'b0, irq_summary}, {7'b0, |(m_stat & m_mask)});
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      rd(A_STAT, "R1 status after reset", 8'h00);
      rd(A_MASK, "R1 mask after reset", 8'h00);
      rd(A_RST, "R12 init pending", 8'h00);
      repeat (15) step();
      rd(A_RST, "R12 still initialising at edge 15", 8'h00);
      step();
      rd(A_RST, "R12 init done at edge 16", 8'h02);
      rd(A_STAT, "R13 steady levels raise nothing", 8'h00);

      ing_parity_err = 1; step(); rd(A_STAT, "R4 ingress parity bit0", 8'h01);
      ing_bus_err = 1;    step(); rd(A_STAT, "R4 ingress bus bit2", 8'h05);
      ing_idle_xfer = 1;  step(); rd(A_STAT, "R4 idle transfer bit3", 8'h0D);
      egr_parity_err = 1; step(); rd(A_STAT, "R4 egress parity bit5", 8'h2D);

      wr(A_STAT, 8'h00); rd(A_STAT, "R2 writing zero keeps bits", 8'h2D);
      wr(A_STAT, 8'h01); rd(A_STAT, "R2 w1c clears only bit0", 8'h2C);
      wr(A_STAT, 8'hFF); rd(A_STAT, "R2 w1c clears all", 8'h00);

      ing_sync_ok = 0; step(); rd(A_STAT, "R3 ingress in to out", 8'h02);
      wr(A_STAT, 8'hFF);
      ing_sync_ok = 1; step(); rd(A_STAT, "R3 ingress out to in", 8'h02);
      egr_sync_ok = 1; step(); rd(A_STAT, "R3 egress out to in", 8'h42);
      wr(A_STAT, 8'hFF);

      ing_clk_ok = 0; step(); rd(A_STAT, "R5 ingress clock loss", 8'h10);
      wr(A_STAT, 8'hFF); step(); step();
      rd(A_STAT, "R5 staying lost sets nothing", 8'h00);
      ing_clk_ok = 1; step(); rd(A_STAT, "R5 recovery sets nothing", 8'h00);
      egr_clk_ok = 0; step(); rd(A_STAT, "R5 egress clock loss", 8'h80);
      wr(A_STAT, 8'hFF); egr_clk_ok = 1; step();

      ing_parity_err = 1; wr(A_STAT, 8'h01);
      rd(A_STAT, "R6 event beats same-cycle clear", 8'h01);

      chk_irq("R7 mask zero hides status");
      check("R7 summary low", {7'b0, irq_summary}, 8'h00);
      wr(A_MASK, 8'hFE); rd(A_MASK, "R7 mask readback", 8'hFE);
      check("R7 unselected bit", {7'b0, irq_summary}, 8'h00);
      wr(A_MASK, 8'h01);
      check("R7 selected bit raises summary", {7'b0, irq_summary}, 8'h01);
      wr(A_STAT, 8'h01);
      check("R7 summary drops after clear", {7'b0, irq_summary}, 8'h00);

      egr_clk_ok = 0; step(); rd(A_STAT, "R8 setup bit7 set", 8'h80);
      low_speed_mode = 1; step(); rd(A_STAT, "R8 low speed forces bit7 off", 8'h00);
      egr_clk_ok = 1; step(); egr_clk_ok = 0; step();
      rd(A_STAT, "R8 no clock loss in low speed", 8'h00);
      low_speed_mode = 0; egr_clk_ok = 1; step();

      wr(A_MASK, 8'hFF); ing_parity_err = 1; step();
      wr(A_RST, 8'h00);
      check("R9 zero write gives no pulse", {7'b0, core_rst_pulse}, 8'h00);
      rd(A_RST, "R9 zero write no effect", 8'h02);
      rd(A_STAT, "R9 zero write keeps status", 8'h01);
      wr(A_RST, 8'h01);
      check("R9 reset pulse raised", {7'b0, core_rst_pulse}, 8'h01);
      rd(A_RST, "R9 busy after request", 8'h01);
      rd(A_STAT, "R10 status cleared", 8'h00);
      rd(A_MASK, "R10 mask cleared", 8'h00);
      step();
      check("R9 pulse lasts one cycle", {7'b0, core_rst_pulse}, 8'h00);
      repeat (14) step();
      rd(A_RST, "R9 still busy at edge 15", 8'h01);
      step();
      rd(A_RST, "R9 complete at edge 16", 8'h02);

      wr(A_RST, 8'hFC); rd(A_RST, "R11 reserved bits ignored", 8'h02);
      ing_bus_err = 1; step();
      wr(6'd5, 8'hFF);
      rd(6'd5, "R11 unmapped offset reads zero", 8'h00);
      rd(A_STAT, "R11 unmapped write leaves status", 8'h04);
      rd(A_MASK, "R11 unmapped write leaves mask", 8'h00);

      for (int i = 0; i < 3000; i++) begin
         int r;
         ing_parity_err = ($urandom % 8) == 0;
         ing_bus_err    = ($urandom % 8) == 0;
         ing_idle_xfer  = ($urandom % 8) == 0;
         egr_parity_err = ($urandom % 8) == 0;
         if (($urandom % 8) == 0) ing_sync_ok = ~ing_sync_ok;
         if (($urandom % 8) == 0) egr_sync_ok = ~egr_sync_ok;
         if (($urandom % 6) == 0) ing_clk_ok = ~ing_clk_ok;
         if (($urandom % 6) == 0) egr_clk_ok = ~egr_clk_ok;
         if (($urandom % 64) == 0) low_speed_mode = ~low_speed_mode;
         r = $urandom % 300;
         bus_addr = 6'($urandom % 6);
         bus_wdata = 8'($urandom);
         if (r == 0) begin
            bus_addr = A_RST; bus_wdata[0] = 1'b1; bus_we = 1;
         end else if (r < 90) begin
            bus_addr = A_STAT; bus_we = 1;
         end else if (r < 130) begin
            bus_addr = A_MASK; bus_we = 1;
         end else if (r < 145) begin
            bus_addr = A_RST; bus_wdata[0] = 1'b0; bus_we = 1;
         end
         step();
         check("R9 random reset pulse", {7'b0, core_rst_pulse}, {7'b0, m_pulse});
         chk_irq("R7 random summary");
         bus_addr = 6'($urandom % 6); #1;
         check("R2 R6 random readback", bus_rdata, exp_rd(bus_addr));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule